// File: doc/BRIEF.md
# Six-Mode Programmable Down-Counter Channel

One timer channel with a 16-bit down counter and a single output pin whose waveform is picked by a three-bit mode code. The six modes are:

- interrupt at terminal count
- gate-triggered one-shot
- rate generator
- square wave
- strobe started by software
- strobe started by the gate

A separate bus block decodes register writes and sequences count bytes. It hands this channel three things:

- a mode-set strobe carrying the mode code and a binary/BCD select
- the assembled count value with a load-complete strobe
- a partial-load strobe for when only the first byte of a count has been written

The channel runs on one system clock. `tick_i` marks each falling edge of the count clock, so every count event is one clock cycle with `tick_i` high. The gate pin acts as a level enable in some modes and as a rising-edge trigger in others. A rising edge that arrives between count events is held until the next count event. `count_o` always shows the live counter so the bus block can latch it. A loaded count of zero stands for the largest count.

Top module: `tmr_channel`

## Requirements
- R1: During and after reset, `out_o` is 0 and `count_o` is 0. A mode-set strobe makes `out_o` 0 for mode 0 and 1 for modes 1 to 5, and it discards any loaded count. Mode codes are: 0 terminal-count interrupt, 1 one-shot, 2 rate generator, 3 square wave, 4 software strobe, 5 gate strobe.
- R2: The counter changes only in cycles with `tick_i` high. A loaded value of 0 counts as 65536 steps in binary and 10000 steps in BCD. For example, in mode 0, 0xFFFF follows 0x0000 in binary and 0x9999 follows it in BCD.
- R3: With `bcd_i` = 1 the count holds four BCD digits, and bits 3:0 hold the lowest digit. A digit that is 0 becomes 9 and borrows from the next digit, so 0x0100 steps to 0x0099.
- R4: Mode 0 with count N: the first count event after the load copies N into the counter. After that, each count event decrements it. `out_o` rises in the count event where the counter reaches 0, which is event N+1 after the load, and stays high until a new mode or a new count is written. Writing a new count drives `out_o` low.
- R5: In mode 0 a partial-load strobe freezes the counter from that cycle onward. The following load-complete strobe restarts counting from the new value, following R4.
- R6: In modes 0 and 4, gate low holds the counter at its value across count events.
- R7: In mode 1 a gate rising edge, once a count is loaded, copies N into the counter and drives `out_o` low. `out_o` returns high in the event where the counter reaches 0, which is N events after the trigger. A count loaded during the pulse does not change the pulse and is used at the next trigger. Before any count is loaded, a trigger has no effect.
- R8: Mode 2 with N ≥ 2: `out_o` is low for exactly one count event in every N. The first low is N events after the start. Gate low forces `out_o` high at the next clock and holds the counter.
- R9: Mode 3 with N ≥ 2: `out_o` is high for (N+1)/2 events and low for N/2 events, rounded down, and this repeats. Even N gives equal halves, and odd N makes the high part one event longer.
- R10: Mode 4: `out_o` stays high after the load and goes low for the single count event in which the counter reaches 0, N+1 events after the load. It strobes only once per load.
- R11: Mode 5: after a gate rising edge, once a count is loaded, `out_o` goes low for exactly one count event, N events after the trigger, and is never low before that. A rising edge seen while `tick_i` is low triggers at the next count event.
- R12: In modes 2 and 3 a gate rising edge restarts the count from N with `out_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count event (count-clock falling edge) this cycle |
| mode_wr_i | input | 1 | Mode-set strobe |
| mode_i | input | 3 | Mode code, sampled on `mode_wr_i` |
| bcd_i | input | 1 | 1 selects BCD counting, sampled on `mode_wr_i` |
| load_val_i | input | W | Assembled count value |
| load_done_i | input | 1 | Count value complete strobe |
| load_part_i | input | 1 | First part of a count written strobe |
| gate_i | input | 1 | Gate: level enable or rising-edge trigger |
| out_o | output | 1 | Registered channel output |
| count_o | output | W | Registered live counter value |

## Verification
The bench sweeps every mode over a range of small counts and compares each cycle of `out_o`, and `count_o` where the mode has a plain down-count, against waveforms computed arithmetically from N.

The wide cases are:
- The zero-means-maximum case in binary and BCD, which catches a design that stops at once or wraps to the wrong digit pattern.
- A BCD odd square-wave count, which exposes a wrong parity step or a wrong step-by-two borrow through a shorter or longer half.

The gate cases are:
- Gate-low holds and the forced-high output in the rate mode, which a level-blind design fails by drifting or by staying low.
- A gate edge that arrives while count events are paused, which an edge detector without memory drops entirely.

The load cases are:
- The mode-0 partial-load freeze, which a design that keeps counting shows as a smaller held value.
- Reloading during a one-shot pulse, which a design that cuts the pulse short shows.
- A trigger before any load, which a design that fires anyway shows as a spurious low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    MD_TCNT    = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SWSTB   = 3'd4,
    MD_HWSTB   = 3'd5
  } tmr_mode_e;
endpackage

// File: rtl/tmr_dec.sv
// Decrement by one or two, in binary or four-bit BCD digits.
module tmr_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         bcd_i,
  input  logic         two_i,
  output logic [W-1:0] nxt_o
);
  localparam int DIG = W / 4;

  logic [W-1:0] bin_res;
  logic [W-1:0] bcd_res;
  logic [DIG-1:0] brw;

  assign bin_res = val_i - (two_i ? W'(2) : W'(1));
  assign brw[0] = 1'b0;

  for (genvar g = 0; g < DIG; g++) begin : g_digit
    logic [3:0] d;
    logic [3:0] s;
    assign d = val_i[4*g +: 4];
    if (g == 0) begin : g_low
      assign s = two_i ? 4'd2 : 4'd1;
    end else begin : g_up
      assign s = {3'b000, brw[g]};
    end
    assign bcd_res[4*g +: 4] = (d >= s) ? (d - s) : (d + 4'd10 - s);
    if (g < DIG - 1) begin : g_brw
      assign brw[g+1] = (d < s);
    end
  end

  assign nxt_o = bcd_i ? bcd_res : bin_res;
endmodule

// File: rtl/tmr_gate_edge.sv
// Gate rising-edge detector; an edge seen between count events is held.
module tmr_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  input  logic gate_i,
  output logic trig_o
);
  logic gate_q;
  logic seen_q;
  logic rise;

  assign rise   = gate_i & ~gate_q;
  assign trig_o = tick_i & (rise | seen_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (clr_i || tick_i) seen_q <= 1'b0;
      else if (rise)       seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         mode_wr_i,
  input  logic [2:0]   mode_i,
  input  logic         bcd_i,
  input  logic [W-1:0] load_val_i,
  input  logic         load_done_i,
  input  logic         load_part_i,
  input  logic         gate_i,
  output logic         out_o,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] ONE = W'(1);

  tmr_mode_e    mode_r;
  logic         bcd_r;
  logic [W-1:0] init_r;
  logic [W-1:0] cnt_r;
  logic         out_r;
  logic         run_r;
  logic         fresh_r;
  logic         halt_r;
  logic         have_r;

  logic [W-1:0] nxt;
  logic [W-1:0] init_even;
  logic         nxt_zero;
  logic         nxt_one;
  logic         step_two;
  logic         halt_now;
  logic         trig;

  assign step_two  = (mode_r == MD_SQUARE) && !cnt_r[0];
  assign nxt_zero  = (nxt == '0);
  assign nxt_one   = (nxt == ONE);
  assign init_even = {init_r[W-1:1], 1'b0};
  assign halt_now  = halt_r | load_part_i;

  tmr_dec #(.W(W)) dec_i (
    .val_i (cnt_r),
    .bcd_i (bcd_r),
    .two_i (step_two),
    .nxt_o (nxt)
  );

  tmr_gate_edge gate_i0 (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (mode_wr_i),
    .tick_i (tick_i),
    .gate_i (gate_i),
    .trig_o (trig)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r  <= MD_TCNT;
      bcd_r   <= 1'b0;
      init_r  <= '0;
      cnt_r   <= '0;
      out_r   <= 1'b0;
      run_r   <= 1'b0;
      fresh_r <= 1'b0;
      halt_r  <= 1'b0;
      have_r  <= 1'b0;
    end else if (mode_wr_i) begin
      mode_r  <= tmr_mode_e'(mode_i);
      bcd_r   <= bcd_i;
      out_r   <= (mode_i != 3'd0);
      run_r   <= 1'b0;
      fresh_r <= 1'b0;
      halt_r  <= 1'b0;
      have_r  <= 1'b0;
    end else begin
      if (tick_i) begin
        case (mode_r)
          MD_TCNT, MD_SWSTB: begin
            if (mode_r == MD_SWSTB) out_r <= 1'b1;
            if (fresh_r) begin
              cnt_r   <= init_r;
              run_r   <= 1'b1;
              fresh_r <= 1'b0;
            end else if (run_r && gate_i && !halt_now) begin
              cnt_r <= nxt;
              if (nxt_zero) begin
                run_r <= 1'b0;
                out_r <= (mode_r == MD_TCNT);
              end
            end
          end
          MD_ONESHOT, MD_HWSTB: begin
            if (mode_r == MD_HWSTB) out_r <= 1'b1;
            if (trig && have_r) begin
              cnt_r <= init_r;
              run_r <= 1'b1;
              out_r <= (mode_r == MD_HWSTB);
            end else if (run_r) begin
              cnt_r <= nxt;
              if (nxt_zero) begin
                run_r <= 1'b0;
                out_r <= (mode_r == MD_ONESHOT);
              end
            end
          end
          MD_RATE: begin
            if (fresh_r || (trig && have_r)) begin
              cnt_r   <= init_r;
              run_r   <= 1'b1;
              fresh_r <= 1'b0;
              out_r   <= 1'b1;
            end else if (run_r && gate_i) begin
              if (cnt_r == ONE) begin
                cnt_r <= init_r;
                out_r <= 1'b1;
              end else begin
                cnt_r <= nxt;
                out_r <= !nxt_one;
              end
            end
          end
          MD_SQUARE: begin
            if (fresh_r || (trig && have_r)) begin
              cnt_r   <= init_r;
              run_r   <= 1'b1;
              fresh_r <= 1'b0;
              out_r   <= 1'b1;
            end else if (run_r && gate_i) begin
              if (nxt_zero) begin
                out_r <= !out_r;
                cnt_r <= out_r ? init_even : init_r;
              end else begin
                cnt_r <= nxt;
              end
            end
          end
          default: ;
        endcase
      end
      if ((mode_r == MD_RATE || mode_r == MD_SQUARE) && !gate_i) out_r <= 1'b1;
      if (load_part_i && mode_r == MD_TCNT) halt_r <= 1'b1;
      if (load_done_i) begin
        init_r  <= load_val_i;
        fresh_r <= 1'b1;
        have_r  <= 1'b1;
        halt_r  <= 1'b0;
        if (mode_r == MD_TCNT) out_r <= 1'b0;
      end
    end
  end

  assign out_o   = out_r;
  assign count_o = cnt_r;

  // R2: the counter only moves on a count event
  p_cnt_only_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !mode_wr_i) |=> $stable(cnt_r));

  // R4: mode 0 output stays high until a new mode or count
  p_m0_out_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MD_TCNT && out_r && !mode_wr_i && !load_done_i) |=> out_r);

  // R6: mode 0 gate low holds the counter
  p_m0_gate_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MD_TCNT && !gate_i && !fresh_r && !mode_wr_i) |=> $stable(cnt_r));

  // R8: mode 2 gate low forces the output high
  p_m2_gate_forces_high_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MD_RATE && !gate_i && !mode_wr_i) |=> out_r);

  // R11: mode 5 strobe lasts one count event
  p_m5_strobe_one_event_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_r == MD_HWSTB && !out_r && tick_i && !mode_wr_i) |=> out_r);
endmodule

// File: tb/tmr_channel_tb_top.sv
module tmr_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        tick_i;
  logic        mode_wr_i;
  logic [2:0]  mode_i;
  logic        bcd_i;
  logic [15:0] load_val_i;
  logic        load_done_i;
  logic        load_part_i;
  logic        gate_i;
  logic        out_o;
  logic [15:0] count_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5ns clk = ~clk;

  tmr_channel #(.W(16)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .mode_wr_i(mode_wr_i), .mode_i(mode_i),
    .bcd_i(bcd_i), .load_val_i(load_val_i), .load_done_i(load_done_i),
    .load_part_i(load_part_i), .gate_i(gate_i), .out_o(out_o), .count_o(count_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic adv();
    @(negedge clk);
  endtask

  task automatic setm(input logic [2:0] m, input logic b);
    mode_i = m; bcd_i = b; mode_wr_i = 1'b1;
    adv();
    mode_wr_i = 1'b0;
  endtask

  task automatic ld(input logic [15:0] v);
    load_val_i = v; load_done_i = 1'b1;
    adv();
    load_done_i = 1'b0;
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; tick_i = 1'b1; mode_wr_i = 1'b0; mode_i = 3'd0; bcd_i = 1'b0;
    load_val_i = '0; load_done_i = 1'b0; load_part_i = 1'b0; gate_i = 1'b1;
    repeat (3) adv();
    chk("R1 reset out", {15'd0, out_o}, 16'd0);
    chk("R1 reset count", count_o, 16'd0);
    rst = 1'b0;
    adv();
    chk("R1 idle out", {15'd0, out_o}, 16'd0);

    // R4 mode 0 sweep
    for (int n = 1; n <= 8; n++) begin
      gate_i = 1'b1;
      setm(3'd0, 1'b0);
      chk("R1 mode0 set out", {15'd0, out_o}, 16'd0);
      ld(16'(n));
      for (int k = 1; k <= n + 3; k++) begin
        adv();
        chk("R4 mode0 out", {15'd0, out_o}, (k >= n + 1) ? 16'd1 : 16'd0);
        chk("R4 mode0 count", count_o, (k <= n + 1) ? 16'(n - k + 1) : 16'd0);
      end
    end

    // R10 mode 4 sweep
    for (int n = 1; n <= 8; n++) begin
      setm(3'd4, 1'b0);
      chk("R1 mode4 set out", {15'd0, out_o}, 16'd1);
      ld(16'(n));
      for (int k = 1; k <= n + 4; k++) begin
        adv();
        chk("R10 mode4 out", {15'd0, out_o}, (k == n + 1) ? 16'd0 : 16'd1);
      end
    end

    // R8 mode 2 sweep
    for (int n = 2; n <= 9; n++) begin
      setm(3'd2, 1'b0);
      ld(16'(n));
      for (int k = 1; k <= 3 * n; k++) begin
        adv();
        chk("R8 mode2 out", {15'd0, out_o}, (((k - 1) % n) == n - 1) ? 16'd0 : 16'd1);
      end
    end

    // R9 mode 3 sweep
    for (int n = 2; n <= 9; n++) begin
      setm(3'd3, 1'b0);
      ld(16'(n));
      for (int k = 1; k <= 3 * n; k++) begin
        adv();
        chk("R9 mode3 out", {15'd0, out_o}, (((k - 1) % n) < (n + 1) / 2) ? 16'd1 : 16'd0);
      end
    end

    // R7 mode 1 sweep
    for (int n = 1; n <= 6; n++) begin
      gate_i = 1'b0;
      setm(3'd1, 1'b0);
      ld(16'(n));
      adv();
      chk("R7 mode1 idle out", {15'd0, out_o}, 16'd1);
      gate_i = 1'b1;
      adv();
      chk("R7 mode1 trigger out", {15'd0, out_o}, 16'd0);
      chk("R7 mode1 trigger count", count_o, 16'(n));
      for (int k = 1; k <= n + 2; k++) begin
        adv();
        chk("R7 mode1 out", {15'd0, out_o}, (k >= n) ? 16'd1 : 16'd0);
      end
    end

    // R11 mode 5 sweep
    for (int n = 1; n <= 6; n++) begin
      gate_i = 1'b0;
      setm(3'd5, 1'b0);
      ld(16'(n));
      gate_i = 1'b1;
      adv();
      chk("R11 mode5 trigger out", {15'd0, out_o}, 16'd1);
      for (int k = 1; k <= n + 2; k++) begin
        adv();
        chk("R11 mode5 out", {15'd0, out_o}, (k == n) ? 16'd0 : 16'd1);
      end
    end

    // R7 trigger before any load, then reload during the pulse
    gate_i = 1'b0;
    setm(3'd1, 1'b0);
    gate_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      adv();
      chk("R7 no count no pulse", {15'd0, out_o}, 16'd1);
    end
    gate_i = 1'b0;
    ld(16'd5);
    adv();
    gate_i = 1'b1;
    adv();
    adv();
    ld(16'd2);
    for (int k = 3; k <= 6; k++) begin
      adv();
      chk("R7 reload mid pulse out", {15'd0, out_o}, (k >= 5) ? 16'd1 : 16'd0);
    end
    gate_i = 1'b0;
    adv();
    gate_i = 1'b1;
    adv();
    for (int k = 1; k <= 3; k++) begin
      adv();
      chk("R7 new count next trigger", {15'd0, out_o}, (k >= 2) ? 16'd1 : 16'd0);
    end

    // R5 partial load freeze
    gate_i = 1'b1;
    setm(3'd0, 1'b0);
    ld(16'd10);
    repeat (3) adv();
    chk("R5 count before freeze", count_o, 16'd8);
    load_part_i = 1'b1;
    adv();
    load_part_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      adv();
      chk("R5 frozen count", count_o, 16'd8);
    end
    ld(16'd3);
    chk("R5 out low after load", {15'd0, out_o}, 16'd0);
    for (int k = 1; k <= 5; k++) begin
      adv();
      chk("R5 restart out", {15'd0, out_o}, (k >= 4) ? 16'd1 : 16'd0);
    end

    // R6 mode 0 gate hold
    setm(3'd0, 1'b0);
    ld(16'd10);
    adv();
    adv();
    gate_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      adv();
      chk("R6 gate low hold", count_o, 16'd9);
    end
    gate_i = 1'b1;
    adv();
    chk("R6 gate high resumes", count_o, 16'd8);

    // R2 count events only with tick
    setm(3'd0, 1'b0);
    ld(16'd9);
    adv();
    adv();
    tick_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      adv();
      chk("R2 no tick hold", count_o, 16'd8);
    end
    tick_i = 1'b1;
    adv();
    chk("R2 tick resumes", count_o, 16'd7);

    // R8 gate low forces high, R12 gate rise restarts
    setm(3'd2, 1'b0);
    ld(16'd4);
    repeat (4) adv();
    chk("R8 mode2 low pulse", {15'd0, out_o}, 16'd0);
    gate_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      adv();
      chk("R8 gate low out", {15'd0, out_o}, 16'd1);
      chk("R8 gate low count", count_o, 16'd1);
    end
    gate_i = 1'b1;
    adv();
    chk("R12 restart count", count_o, 16'd4);
    for (int k = 2; k <= 8; k++) begin
      adv();
      chk("R12 restart out", {15'd0, out_o}, (((k - 1) % 4) == 3) ? 16'd0 : 16'd1);
    end

    // R3 BCD borrow across digits
    setm(3'd0, 1'b1);
    ld(16'h0100);
    adv();
    adv();
    chk("R3 bcd borrow", count_o, 16'h0099);
    adv();
    chk("R3 bcd step", count_o, 16'h0098);

    // R9 BCD odd square wave (eleven)
    setm(3'd3, 1'b1);
    ld(16'h0011);
    for (int k = 1; k <= 33; k++) begin
      adv();
      chk("R9 bcd mode3 out", {15'd0, out_o}, (((k - 1) % 11) < 6) ? 16'd1 : 16'd0);
    end

    // R2 zero means maximum, BCD
    setm(3'd0, 1'b1);
    ld(16'h0000);
    adv();
    adv();
    chk("R2 bcd max wrap", count_o, 16'h9999);
    for (int k = 3; k <= 10002; k++) begin
      adv();
      if (k == 10000) chk("R2 bcd max not yet", {15'd0, out_o}, 16'd0);
      if (k == 10001) chk("R2 bcd max terminal", {15'd0, out_o}, 16'd1);
    end

    // R2 zero means maximum, binary
    setm(3'd0, 1'b0);
    ld(16'h0000);
    adv();
    adv();
    chk("R2 bin max wrap", count_o, 16'hFFFF);
    for (int k = 3; k <= 65538; k++) begin
      adv();
      if (k == 65536) chk("R2 bin max not yet", {15'd0, out_o}, 16'd0);
      if (k == 65537) chk("R2 bin max terminal", {15'd0, out_o}, 16'd1);
    end

    // R11 gate edge while tick low is remembered
    gate_i = 1'b0;
    setm(3'd5, 1'b0);
    ld(16'd3);
    tick_i = 1'b0;
    gate_i = 1'b1;
    adv();
    gate_i = 1'b0;
    adv();
    tick_i = 1'b1;
    adv();
    chk("R11 held edge count", count_o, 16'd3);
    chk("R11 held edge out", {15'd0, out_o}, 16'd1);
    for (int k = 1; k <= 4; k++) begin
      adv();
      chk("R11 held edge strobe", {15'd0, out_o}, (k == 3) ? 16'd0 : 16'd1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule